// File: doc/BRIEF.md
# Commit-Reconcile Cache Controller

This block is the cache controller of one processor under a memory model in which ordering is made explicit by instructions rather than by snooping. Every address is either absent from the cache or held in exactly one line whose state is Clean or Dirty. The processor presents one instruction at a time: a local load, a local store, a commit or a reconcile. The controller retires that instruction only when the line state permits it, and one cycle later returns a response that carries the opcode and, for a load, the data.

When the instruction at the head cannot retire yet, the controller performs one background action per cycle that moves the line toward a state that allows retirement. A missing line is fetched from memory as Clean. A Dirty line named by a commit is written back and becomes Clean. A Clean line named by a reconcile is purged. When a fill is needed and every slot is occupied, a victim chosen in round-robin order is freed first: a Dirty victim is written back and then purged, and a Clean victim is purged directly. Memory is reached through a request/acknowledge port that has at most one access outstanding.

Top module: `crc_cache_ctrl`

## Requirements
- R1: After reset, and again after any later reset, no address is cached and `rsp_valid` and `mem_req` are low. The first access to any address therefore needs a memory read, and a commit that follows a reset writes nothing.
- R2: A load (opcode 0) to a cached line retires without any memory access and returns the line value. The line state does not change.
- R3: A store (opcode 1) retires only on a cached line. It replaces the value and leaves the line Dirty, so later loads return the new value and a later commit writes it to memory.
- R4: A load or store to an absent address first causes exactly one memory read of that address, installs the result as Clean and then retires. An address is never held in two lines, so a repeated access reads nothing.
- R5: A commit (opcode 2) to a Dirty line causes exactly one memory write of the line's address and value and then retires. A commit to a Clean or absent line retires with no memory access.
- R6: A reconcile (opcode 3) to a Clean line purges it without any memory access, so the next load of that address reads memory again. A reconcile to a Dirty or absent line retires with no memory access and leaves a Dirty line in place.
- R7: A Clean line is never written to memory, whether it is committed, reconciled or evicted.
- R8: A fill goes into the lowest-numbered empty slot. When every slot is full, the victim is the slot named by a pointer that is 0 after reset and advances by one, wrapping, on each eviction. A Dirty victim is written back before it is purged, and a Clean victim is purged without a write.
- R9: The cycle after a handshake (`req_valid` and `req_ready` both high), `rsp_valid` is high for exactly one cycle. `rsp_op` equals the retired opcode, and `rsp_rdata` carries the load value, or zero for the other opcodes.
- R10: `mem_req` stays high, with `mem_addr`, `mem_we` and `mem_wdata` held constant, until the cycle in which `mem_ack` is seen, and drops in the next cycle. No instruction retires while an access is outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An instruction is presented and held until accepted |
| req_ready | output | 1 | The instruction retires in this cycle |
| req_op | input | 2 | Opcode: 0 load, 1 store, 2 commit, 3 reconcile |
| req_addr | input | AW | Address of the instruction |
| req_wdata | input | DW | Store value |
| rsp_valid | output | 1 | Response pulse, one cycle after retirement |
| rsp_op | output | 2 | Opcode of the retired instruction |
| rsp_rdata | output | DW | Load value, zero for other opcodes |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 for a write-back, 0 for a fill read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Write-back value |
| mem_ack | input | 1 | Memory completes the pending access |
| mem_rdata | input | DW | Fill data, valid while `mem_ack` is high |

## Verification
The registered response of one instruction is presented in the same cycle as the next instruction's first decision, and that decision may be a purge, the start of a fill or the start of a write-back. The bench provokes this overlap by presenting every instruction immediately after the previous handshake, with no idle cycle between them. It judges the overlap from both sides: the response must still carry the previous opcode and data, and the new instruction must produce exactly its expected count of memory reads and writes and return the correct value. A memory model with a one-cycle acknowledge lets each fill and write-back be counted, and its contents confirm what each write-back stored.

// File: rtl/crc_pkg.sv
package crc_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_COMMIT = 2'd2,
        OP_RECON = 2'd3
    } crc_op_e;

    typedef enum logic [1:0] {
        ST_EVAL  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WBACK = 2'd2
    } crc_state_e;

    typedef enum logic [2:0] {
        LC_NONE    = 3'd0,
        LC_INSTALL = 3'd1,
        LC_WRITE   = 3'd2,
        LC_CLEAN   = 3'd3,
        LC_PURGE   = 3'd4
    } crc_lcmd_e;

    typedef enum logic [2:0] {
        ACT_NONE   = 3'd0,
        ACT_RETIRE = 3'd1,
        ACT_FILL   = 3'd2,
        ACT_WBACK  = 3'd3,
        ACT_VWB    = 3'd4,
        ACT_PURGE  = 3'd5,
        ACT_VPURGE = 3'd6
    } crc_act_e;

endpackage

// File: rtl/crc_lookup.sv
module crc_lookup #(
    parameter int NLINES = 4,
    parameter int AW     = 6,
    parameter int IDXW   = 2
) (
    input  logic [NLINES-1:0]         line_valid,
    input  logic [NLINES-1:0][AW-1:0] line_tag,
    input  logic [AW-1:0]             addr,
    output logic [NLINES-1:0]         hit_vec,
    output logic                      hit,
    output logic [IDXW-1:0]           hit_idx,
    output logic                      free_found,
    output logic [IDXW-1:0]           free_idx
);

    // Tag compare per slot
    for (genvar g = 0; g < NLINES; g++) begin : g_cmp
        assign hit_vec[g] = line_valid[g] && (line_tag[g] == addr);
    end

    assign hit = |hit_vec;

    // Lowest-numbered match and lowest-numbered empty slot
    always_comb begin
        hit_idx    = '0;
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = NLINES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_idx = IDXW'(i);
            end
            if (!line_valid[i]) begin
                free_idx   = IDXW'(i);
                free_found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/crc_line_store.sv
module crc_line_store
    import crc_pkg::*;
#(
    parameter int NLINES = 4,
    parameter int AW     = 6,
    parameter int DW     = 16,
    parameter int IDXW   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  crc_lcmd_e                 cmd_kind,
    input  logic [IDXW-1:0]           cmd_idx,
    input  logic [AW-1:0]             cmd_tag,
    input  logic [DW-1:0]             cmd_data,
    output logic [NLINES-1:0]         line_valid,
    output logic [NLINES-1:0]         line_dirty,
    output logic [NLINES-1:0][AW-1:0] line_tag,
    output logic [NLINES-1:0][DW-1:0] line_data
);

    typedef struct packed {
        logic [NLINES-1:0]         valid;
        logic [NLINES-1:0]         dirty;
        logic [NLINES-1:0][AW-1:0] tag;
        logic [NLINES-1:0][DW-1:0] data;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (cmd_kind)
            LC_INSTALL: begin
                st_d.valid[cmd_idx] = 1'b1;
                st_d.dirty[cmd_idx] = 1'b0;
                st_d.tag[cmd_idx]   = cmd_tag;
                st_d.data[cmd_idx]  = cmd_data;
            end
            LC_WRITE: begin
                st_d.dirty[cmd_idx] = 1'b1;
                st_d.data[cmd_idx]  = cmd_data;
            end
            LC_CLEAN: begin
                st_d.dirty[cmd_idx] = 1'b0;
            end
            LC_PURGE: begin
                st_d.valid[cmd_idx] = 1'b0;
                st_d.dirty[cmd_idx] = 1'b0;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign line_valid = st_q.valid;
    assign line_dirty = st_q.dirty;
    assign line_tag   = st_q.tag;
    assign line_data  = st_q.data;

endmodule

// File: rtl/crc_victim_ptr.sv
module crc_victim_ptr #(
    parameter int NLINES = 4,
    parameter int IDXW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    output logic [IDXW-1:0] ptr
);

    localparam logic [IDXW-1:0] LAST = IDXW'(NLINES - 1);

    logic [IDXW-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (advance) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/crc_cache_ctrl.sv
module crc_cache_ctrl
    import crc_pkg::*;
#(
    parameter int AW     = 6,
    parameter int DW     = 16,
    parameter int NLINES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [1:0]    rsp_op,
    output logic [DW-1:0] rsp_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    localparam int IDXW = (NLINES > 1) ? $clog2(NLINES) : 1;

    typedef struct packed {
        crc_state_e      state;
        logic [IDXW-1:0] slot;
        logic            we;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
        logic            rsp_v;
        logic [1:0]      rsp_op;
        logic [DW-1:0]   rsp_data;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    // Line store view
    logic [NLINES-1:0]         line_valid;
    logic [NLINES-1:0]         line_dirty;
    logic [NLINES-1:0][AW-1:0] line_tag;
    logic [NLINES-1:0][DW-1:0] line_data;

    // Lookup results
    logic [NLINES-1:0] hit_vec;
    logic              hit;
    logic [IDXW-1:0]   hit_idx;
    logic              free_found;
    logic [IDXW-1:0]   free_idx;
    logic              hit_dirty;
    logic [DW-1:0]     hit_data;

    // Victim selection
    logic [IDXW-1:0] vptr;
    logic            vic_adv;

    // Line store command
    crc_lcmd_e       cmd_kind;
    logic [IDXW-1:0] cmd_idx;
    logic [AW-1:0]   cmd_tag;
    logic [DW-1:0]   cmd_data;

    crc_op_e  op;
    crc_act_e act;

    assign op = crc_op_e'(req_op);

    crc_line_store #(
        .NLINES (NLINES),
        .AW     (AW),
        .DW     (DW),
        .IDXW   (IDXW)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_kind   (cmd_kind),
        .cmd_idx    (cmd_idx),
        .cmd_tag    (cmd_tag),
        .cmd_data   (cmd_data),
        .line_valid (line_valid),
        .line_dirty (line_dirty),
        .line_tag   (line_tag),
        .line_data  (line_data)
    );

    crc_lookup #(
        .NLINES (NLINES),
        .AW     (AW),
        .IDXW   (IDXW)
    ) u_lookup (
        .line_valid (line_valid),
        .line_tag   (line_tag),
        .addr       (req_addr),
        .hit_vec    (hit_vec),
        .hit        (hit),
        .hit_idx    (hit_idx),
        .free_found (free_found),
        .free_idx   (free_idx)
    );

    crc_victim_ptr #(
        .NLINES (NLINES),
        .IDXW   (IDXW)
    ) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (vic_adv),
        .ptr     (vptr)
    );

    assign hit_dirty = hit && line_dirty[hit_idx];
    assign hit_data  = line_data[hit_idx];

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.rsp_v = 1'b0;
        req_ready   = 1'b0;
        vic_adv     = 1'b0;
        cmd_kind    = LC_NONE;
        cmd_idx     = '0;
        cmd_tag     = req_addr;
        cmd_data    = req_wdata;
        act         = ACT_NONE;

        // Pick the single action of this cycle
        case (ctl_q.state)
            ST_EVAL: begin
                if (req_valid) begin
                    unique case (op)
                        OP_LOAD, OP_STORE: begin
                            if (hit) begin
                                act = ACT_RETIRE;
                            end else if (free_found) begin
                                act = ACT_FILL;
                            end else if (line_dirty[vptr]) begin
                                act = ACT_VWB;
                            end else begin
                                act = ACT_VPURGE;
                            end
                        end
                        OP_COMMIT: act = hit_dirty ? ACT_WBACK : ACT_RETIRE;
                        OP_RECON:  act = (hit && !hit_dirty) ? ACT_PURGE : ACT_RETIRE;
                    endcase
                end
            end
            ST_FILL: begin
                if (mem_ack) begin
                    cmd_kind    = LC_INSTALL;
                    cmd_idx     = ctl_q.slot;
                    cmd_tag     = ctl_q.addr;
                    cmd_data    = mem_rdata;
                    ctl_d.state = ST_EVAL;
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    cmd_kind    = LC_CLEAN;
                    cmd_idx     = ctl_q.slot;
                    ctl_d.state = ST_EVAL;
                end
            end
            default: begin
                ctl_d.state = ST_EVAL;
            end
        endcase

        // Carry it out
        case (act)
            ACT_RETIRE: begin
                req_ready      = 1'b1;
                ctl_d.rsp_v    = 1'b1;
                ctl_d.rsp_op   = req_op;
                ctl_d.rsp_data = (op == OP_LOAD) ? hit_data : '0;
                if (op == OP_STORE) begin
                    cmd_kind = LC_WRITE;
                    cmd_idx  = hit_idx;
                    cmd_data = req_wdata;
                end
            end
            ACT_FILL: begin
                ctl_d.state = ST_FILL;
                ctl_d.slot  = free_idx;
                ctl_d.we    = 1'b0;
                ctl_d.addr  = req_addr;
                ctl_d.wdata = '0;
            end
            ACT_WBACK: begin
                ctl_d.state = ST_WBACK;
                ctl_d.slot  = hit_idx;
                ctl_d.we    = 1'b1;
                ctl_d.addr  = req_addr;
                ctl_d.wdata = hit_data;
            end
            ACT_VWB: begin
                ctl_d.state = ST_WBACK;
                ctl_d.slot  = vptr;
                ctl_d.we    = 1'b1;
                ctl_d.addr  = line_tag[vptr];
                ctl_d.wdata = line_data[vptr];
            end
            ACT_PURGE: begin
                cmd_kind = LC_PURGE;
                cmd_idx  = hit_idx;
            end
            ACT_VPURGE: begin
                cmd_kind = LC_PURGE;
                cmd_idx  = vptr;
                vic_adv  = 1'b1;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_EVAL;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid = ctl_q.rsp_v;
    assign rsp_op    = ctl_q.rsp_op;
    assign rsp_rdata = ctl_q.rsp_data;
    assign mem_req   = (ctl_q.state != ST_EVAL);
    assign mem_we    = ctl_q.we;
    assign mem_addr  = ctl_q.addr;
    assign mem_wdata = ctl_q.wdata;

endmodule

// File: rtl/crc_cache_ctrl_chk.sv
module crc_cache_ctrl_chk #(
    parameter int AW     = 6,
    parameter int DW     = 16,
    parameter int NLINES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_op,
    input logic              rsp_valid,
    input logic [1:0]        rsp_op,
    input logic [DW-1:0]     rsp_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [AW-1:0]     mem_addr,
    input logic [DW-1:0]     mem_wdata,
    input logic              mem_ack,
    input logic [NLINES-1:0] hit_vec,
    input logic              hit,
    input logic              hit_dirty
);

    logic retire;
    assign retire = req_valid && req_ready;

    AST_LOAD_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && req_op == 2'd0) |-> hit);  // R2

    AST_STORE_ON_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && req_op == 2'd1) |-> hit);  // R3

    AST_SINGLE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));  // R4

    AST_COMMIT_NOT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && req_op == 2'd2) |-> !hit_dirty);  // R5

    AST_RECON_NOT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && req_op == 2'd3) |-> (!hit || hit_dirty));  // R6

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (rsp_valid && rsp_op == $past(req_op)));  // R9

    AST_RSP_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(retire));  // R9

    AST_RSP_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_op != 2'd0) |-> (rsp_rdata == '0));  // R9

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));  // R10

    AST_MEM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> !mem_req);  // R10

    AST_NO_RETIRE_IN_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);  // R10

endmodule

bind crc_cache_ctrl crc_cache_ctrl_chk #(
    .AW     (AW),
    .DW     (DW),
    .NLINES (NLINES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .rsp_valid (rsp_valid),
    .rsp_op    (rsp_op),
    .rsp_rdata (rsp_rdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .hit_dirty (hit_dirty)
);

// File: tb/crc_cache_ctrl_bench.sv
`timescale 1ns/1ps
module crc_cache_ctrl_bench;

    localparam int AW = 6;
    localparam int DW = 16;
    localparam int NL = 4;

    localparam logic [1:0] LD = 2'd0;
    localparam logic [1:0] ST = 2'd1;
    localparam logic [1:0] CM = 2'd2;
    localparam logic [1:0] RC = 2'd3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_op;
    logic [DW-1:0] rsp_rdata;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata;

    always #2.5 clk = ~clk;

    crc_cache_ctrl #(.AW(AW), .DW(DW), .NLINES(NL)) u_crc_cache_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_op    (rsp_op),
        .rsp_rdata (rsp_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int hold_bad = 0;

    // Memory model: untouched words hold a computed pattern
    logic [63:0]   tb_wr = '0;
    logic [DW-1:0] tb_val [64];

    function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
        return 16'h0100 + 16'(a) * 16'd7;
    endfunction

    assign mem_rdata = tb_wr[mem_addr] ? tb_val[mem_addr] : init_val(mem_addr);

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    wr_cnt <= wr_cnt + 1;
                    tb_wr[mem_addr] <= 1'b1;
                    tb_val[mem_addr] <= mem_wdata;
                end else begin
                    rd_cnt <= rd_cnt + 1;
                end
            end
        end
    end

    // Memory request stability monitor (R10)
    logic          prev_pend = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    logic          prev_we = 1'b0;
    logic [DW-1:0] prev_wd = '0;
    always @(posedge clk) begin
        if (rst_n && prev_pend &&
            (!mem_req || mem_addr !== prev_addr || mem_we !== prev_we || mem_wdata !== prev_wd)) begin
            hold_bad <= hold_bad + 1;
        end
        prev_pend <= rst_n && mem_req && !mem_ack;
        prev_addr <= mem_addr;
        prev_we   <= mem_we;
        prev_wd   <= mem_wdata;
    end

    task automatic check(input int rq, input string what, input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    logic          got_v;
    logic [1:0]    got_op;
    logic [DW-1:0] got_data;
    int            got_rd;
    int            got_wr;

    // Present one instruction, wait for retirement, capture response
    task automatic do_req(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] wd);
        int r0;
        int w0;
        int guard;
        r0 = rd_cnt;
        w0 = wr_cnt;
        guard = 0;
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = a;
        req_wdata = wd;
        #0.1;
        while (!req_ready && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        got_v    = rsp_valid;
        got_op   = rsp_op;
        got_data = rsp_rdata;
        got_rd   = rd_cnt - r0;
        got_wr   = wr_cnt - w0;
    endtask

    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] exp;
        logic [1:0]    nrd;
        logic [1:0]    nwr;
        logic [3:0]    rq;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{LD, 6'd5,  16'h0000, 16'h0123, 2'd1, 2'd0, 4'd4},  // R4 cold miss fills
        '{LD, 6'd5,  16'h0000, 16'h0123, 2'd0, 2'd0, 4'd2},  // R2 hit, no second copy
        '{CM, 6'd5,  16'h0000, 16'h0000, 2'd0, 2'd0, 4'd5},  // R5 commit on Clean
        '{ST, 6'd5,  16'hBEEF, 16'h0000, 2'd0, 2'd0, 4'd3},  // R3 store on present line
        '{LD, 6'd5,  16'h0000, 16'hBEEF, 2'd0, 2'd0, 4'd3},  // R3 new value seen
        '{RC, 6'd5,  16'h0000, 16'h0000, 2'd0, 2'd0, 4'd6},  // R6 reconcile on Dirty
        '{CM, 6'd5,  16'h0000, 16'h0000, 2'd0, 2'd1, 4'd5},  // R5 commit writes back
        '{CM, 6'd5,  16'h0000, 16'h0000, 2'd0, 2'd0, 4'd7},  // R7 Clean line not written
        '{RC, 6'd5,  16'h0000, 16'h0000, 2'd0, 2'd0, 4'd6},  // R6 purge without memory
        '{LD, 6'd5,  16'h0000, 16'hBEEF, 2'd1, 2'd0, 4'd6},  // R6 refetch after purge
        '{CM, 6'd9,  16'h0000, 16'h0000, 2'd0, 2'd0, 4'd5},  // R5 commit on absent
        '{RC, 6'd9,  16'h0000, 16'h0000, 2'd0, 2'd0, 4'd6},  // R6 reconcile on absent
        '{ST, 6'd9,  16'h1234, 16'h0000, 2'd1, 2'd0, 4'd4},  // R4 store miss fills first
        '{ST, 6'd10, 16'h2222, 16'h0000, 2'd1, 2'd0, 4'd4},  // R4
        '{LD, 6'd11, 16'h0000, 16'h014D, 2'd1, 2'd0, 4'd8},  // R8 last free slot
        '{LD, 6'd12, 16'h0000, 16'h0154, 2'd1, 2'd0, 4'd7},  // R7 Clean victim slot 0
        '{LD, 6'd13, 16'h0000, 16'h015B, 2'd1, 2'd1, 4'd8},  // R8 Dirty victim slot 1
        '{LD, 6'd9,  16'h0000, 16'h1234, 2'd1, 2'd1, 4'd8},  // R8 Dirty victim slot 2
        '{LD, 6'd10, 16'h0000, 16'h2222, 2'd1, 2'd0, 4'd8},  // R8 Clean victim slot 3
        '{LD, 6'd12, 16'h0000, 16'h0154, 2'd0, 2'd0, 4'd2}   // R2 slot 0 survived
    };

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(1, "rsp_valid in reset", rsp_valid, 0);
        check(1, "mem_req in reset", mem_req, 0);
        check(1, "req_ready idle", req_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk, back-to-back to overlap response and next action
        for (int i = 0; i < NV; i++) begin
            do_req(VECS[i].op, VECS[i].addr, VECS[i].wdata);
            check(int'(VECS[i].rq), "rsp_valid (R9)", got_v, 1);
            check(int'(VECS[i].rq), "rsp_op (R9)", got_op, VECS[i].op);
            check(int'(VECS[i].rq), "rsp_rdata", got_data, VECS[i].exp);
            check(int'(VECS[i].rq), "memory reads", got_rd, VECS[i].nrd);
            check(int'(VECS[i].rq), "memory writes", got_wr, VECS[i].nwr);
        end

        // R9 response is a single-cycle pulse
        @(negedge clk);
        check(9, "rsp_valid second cycle", rsp_valid, 0);

        // R8 contents written back by evictions
        check(8, "memory word 9", tb_val[9], 16'h1234);
        check(8, "memory word 10", tb_val[10], 16'h2222);

        // R1 reset in mid-run empties the cache
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(1, "rsp_valid after reset", rsp_valid, 0);
        check(1, "mem_req after reset", mem_req, 0);
        rst_n = 1'b1;
        @(negedge clk);
        do_req(LD, 6'd12, '0);
        check(1, "reads after reset", got_rd, 1);
        check(1, "data after reset", got_data, 16'h0154);
        do_req(ST, 6'd12, 16'h5A5A);
        do_req(RC, 6'd12, '0);
        check(6, "Dirty kept by reconcile, reads", got_rd, 0);
        do_req(LD, 6'd12, '0);
        check(6, "Dirty kept by reconcile, data", got_data, 16'h5A5A);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        do_req(CM, 6'd12, '0);
        check(1, "commit after reset writes", got_wr, 0);
        check(1, "memory word 12 unchanged", tb_wr[12], 0);

        // R10 memory request held until acknowledged
        check(10, "mem request hold violations", hold_bad, 0);

        summary();
        $finish;
    end

endmodule